// File: doc/BRIEF.md
# Saturating Rounding Variable Lane Shifter

This block shifts every element of a packed 64-bit word by its own signed amount. The word is split into eight 8-bit, four 16-bit, two 32-bit or one 64-bit element, and each element reads its amount from the matching element of a second word. A positive amount moves the element left. A negative amount moves it right. Right shifts can round to nearest with ties upward. Left shifts can clamp to the element's range.

Elements are interpreted in one of three ways: signed source with signed result, unsigned source with unsigned result, or signed source with unsigned result. Every shift magnitude has a defined result, including magnitudes at or past the element width. When any element clamps during an accepted operation, a sticky flag is set. Only a dedicated clear input resets that flag. The result and the flag are registered, and both appear one cycle after a valid input.

Top module: `sat_rnd_vshift`

## Requirements
- R1: `esize` selects the element width: 0 is 8-bit, 1 is 16-bit, 2 is 32-bit and 3 is 64-bit. Element i occupies bits [i*W +: W] of both words. Its amount is bits [i*W +: 8] of `shamt`, read as a two's-complement value from -128 to 127. The higher bits of each amount element have no effect.
- R2: An amount of -n with n below the width, and rounding off, shifts the element right by n. The shift is arithmetic in signed-result mode and logical in the unsigned modes.
- R3: With rounding on and a right shift by n, the result is x>>(n-1), then shifted right once more, plus the last bit shifted out. This is round-half-up.
- R4: In signed mode (`mode`=0), an amount at or below -W returns 0 when rounding is on, and returns the sign bit copied into every position when rounding is off.
- R5: In the unsigned modes, an amount at or below -(W+1) with rounding on, or at or below -W with rounding off, returns 0. An amount of exactly -W with rounding on returns the element's top bit.
- R6: A left shift by 0 to W-1 with saturation off returns the low W bits of the shifted value.
- R7: A left shift by 0 to W-1 that overflows, with saturation on, clamps the element. The overflow test depends on the mode: in signed mode the shifted value no longer sign-extends from W bits; in unsigned mode nonzero bits are lost above W. Signed mode clamps to the most positive value for a non-negative source and the most negative value for a negative source. The unsigned modes clamp to all ones. A clamp is a saturation event.
- R8: A left shift by W or more returns 0, except when saturation is on and the source is nonzero. In that case the element clamps as in R7 and raises an event. A zero source never raises an event.
- R9: `mode` 2 is signed source with unsigned result. With saturation on, a negative source returns 0 and raises an event. Every other case follows the unsigned path on the raw element bits. `mode` 1 and the unused code 3 are both unsigned.
- R10: When `in_valid` is high, `out_valid` is high and `result` holds that operation's value one cycle later. Without `in_valid`, `out_valid` is low and `result` keeps its value.
- R11: `sat_flag` is set one cycle after an accepted operation in which any element raised an event. It stays set until `sat_clr`. When a clear and an event arrive in the same cycle, the flag ends set. Nothing sets the flag while saturation is off.
- R12: Synchronous active-high `rst` clears `out_valid`, `result` and `sat_flag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operation accepted this cycle |
| operand | input | 64 | Packed source elements |
| shamt | input | 64 | Packed signed shift amounts |
| esize | input | 2 | Element width code |
| mode | input | 2 | Signedness mode code |
| round_en | input | 1 | Round right shifts |
| sat_en | input | 1 | Clamp overflowing left shifts |
| sat_clr | input | 1 | Clear the sticky flag |
| out_valid | output | 1 | Result register updated |
| result | output | 64 | Packed shifted elements |
| sat_flag | output | 1 | Sticky saturation flag |

## Verification
The corner cases sit at amounts of exactly -W, -(W+1), W-1 and W for each element width. Random bytes almost never land on these amounts, and the right combination of rounding, saturation and mode makes them rarer still. To reach them, the stimulus builds each lane's amount from a table of values taken relative to the current width, fills the unused high bits of each amount element with noise, and pairs the table with operands such as zero, all ones and the most negative value. Directed sequences then clear the flag just before zero-source saturating shifts and just before a clear that coincides with an event. This isolates whether the flag was set by a real event.

// File: rtl/vshift_pkg.sv
package vshift_pkg;

    localparam int AMT_W = 8;            // signed per-lane amount width
    localparam int AX    = AMT_W + 2;    // headroom for -(W+1) comparisons

    typedef enum logic [1:0] {
        SZ_B = 2'd0,
        SZ_H = 2'd1,
        SZ_S = 2'd2,
        SZ_D = 2'd3
    } esize_e;

    typedef enum logic [1:0] {
        MD_SS  = 2'd0,   // signed in, signed out
        MD_UU  = 2'd1,   // unsigned in, unsigned out
        MD_SU  = 2'd2,   // signed in, unsigned out
        MD_RSV = 2'd3    // behaves as unsigned
    } vmode_e;

    typedef struct packed {
        logic   rnd;
        logic   sat;
        vmode_e mode;
    } vctl_t;

    function automatic int lane_bits(input esize_e sz);
        return 8 << int'(sz);
    endfunction

endpackage

// File: rtl/vshift_lane.sv
module vshift_lane
    import vshift_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0]     src,
    input  logic [AMT_W-1:0] amt,
    input  vctl_t            ctl,
    output logic [W-1:0]     res,
    output logic             sat_ev
);
    localparam logic signed [AX-1:0] NEG_W  = AX'(-W);
    localparam logic signed [AX-1:0] NEG_W1 = AX'(-(W + 1));
    localparam logic signed [AX-1:0] POS_W  = AX'(W);

    logic signed [AX-1:0] a;
    logic [6:0]           n7;
    logic                 sgn_md;
    logic                 ext;
    logic signed [W:0]    xs;
    logic signed [W:0]    t;
    logic [2*W-1:0]       wide;
    logic                 ovf;
    logic [W-1:0]         sat_val;
    logic                 zero_src;

    assign a        = {{(AX-AMT_W){amt[AMT_W-1]}}, amt};
    assign n7       = 7'(0 - a);
    assign sgn_md   = (ctl.mode == MD_SS);
    assign ext      = sgn_md & src[W-1];
    assign xs       = {ext, src};
    assign zero_src = ~|src;
    assign sat_val  = sgn_md ? (src[W-1] ? {1'b1, {(W-1){1'b0}}} : {1'b0, {(W-1){1'b1}}})
                             : {W{1'b1}};

    always_comb begin
        res    = '0;
        sat_ev = 1'b0;
        t      = '0;
        wide   = '0;
        ovf    = 1'b0;
        if (ctl.mode == MD_SU && ctl.sat && src[W-1]) begin
            sat_ev = 1'b1;
        end else if (a[AX-1]) begin
            if (sgn_md && a <= NEG_W) begin
                res = ctl.rnd ? '0 : {W{src[W-1]}};
            end else if (!sgn_md && a <= (ctl.rnd ? NEG_W1 : NEG_W)) begin
                res = '0;
            end else if (ctl.rnd) begin
                t   = xs >>> (n7 - 7'd1);
                res = t[W:1] + {{(W-1){1'b0}}, t[0]};
            end else begin
                t   = xs >>> n7;
                res = t[W-1:0];
            end
        end else if (a < POS_W) begin
            wide = {{W{ext}}, src} << a[6:0];
            if (sgn_md)
                ovf = !((&wide[2*W-1:W-1]) || !(|wide[2*W-1:W-1]));
            else
                ovf = |wide[2*W-1:W];
            if (ovf && ctl.sat) begin
                res    = sat_val;
                sat_ev = 1'b1;
            end else begin
                res = wide[W-1:0];
            end
        end else if (ctl.sat && !zero_src) begin
            res    = sat_val;
            sat_ev = 1'b1;
        end
    end

endmodule

// File: rtl/vshift_bank.sv
module vshift_bank
    import vshift_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int W      = 8
) (
    input  logic [DATA_W-1:0] operand,
    input  logic [DATA_W-1:0] shamt,
    input  vctl_t             ctl,
    output logic [DATA_W-1:0] res,
    output logic              sat_any
);
    localparam int NLANE = DATA_W / W;

    logic [NLANE-1:0] lane_sat;

    for (genvar i = 0; i < NLANE; i++) begin : g_lane
        vshift_lane #(.W(W)) u_lane (
            .src    (operand[i*W +: W]),
            .amt    (shamt[i*W +: AMT_W]),
            .ctl    (ctl),
            .res    (res[i*W +: W]),
            .sat_ev (lane_sat[i])
        );
        if (W > AMT_W) begin : g_hi
            logic unused_hi;
            assign unused_hi = ^shamt[i*W+AMT_W +: W-AMT_W];
        end
    end

    assign sat_any = |lane_sat;

endmodule

// File: rtl/sat_rnd_vshift.sv
module sat_rnd_vshift
    import vshift_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] operand,
    input  logic [DATA_W-1:0] shamt,
    input  logic [1:0]        esize,
    input  logic [1:0]        mode,
    input  logic              round_en,
    input  logic              sat_en,
    input  logic              sat_clr,
    output logic              out_valid,
    output logic [DATA_W-1:0] result,
    output logic              sat_flag
);
    localparam int NSIZE = 4;

    vctl_t             ctl;
    logic [DATA_W-1:0] bank_res [NSIZE];
    logic [NSIZE-1:0]  bank_sat;
    logic [DATA_W-1:0] sel_res;
    logic              sel_sat;

    assign ctl = '{rnd: round_en, sat: sat_en, mode: vmode_e'(mode)};

    for (genvar g = 0; g < NSIZE; g++) begin : g_size
        vshift_bank #(.DATA_W(DATA_W), .W(lane_bits(esize_e'(g)))) u_bank (
            .operand (operand),
            .shamt   (shamt),
            .ctl     (ctl),
            .res     (bank_res[g]),
            .sat_any (bank_sat[g])
        );
    end

    assign sel_res = bank_res[esize];
    assign sel_sat = bank_sat[esize];

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            result    <= '0;
            sat_flag  <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid)
                result <= sel_res;
            sat_flag <= (sat_flag & ~sat_clr) | (in_valid & sel_sat);
        end
    end

    AST_VALID_LAT: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);                                   // R10
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);                                 // R10
    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(result));                            // R10
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        sat_flag && !sat_clr |=> sat_flag);                        // R11
    AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (rst)
        sat_clr && !in_valid |=> !sat_flag);                       // R11
    AST_SAT_OFF_NO_SET: assert property (@(posedge clk) disable iff (rst)
        !sat_flag && (!in_valid || !sat_en) |=> !sat_flag);        // R11
    AST_ZERO_NO_SAT: assert property (@(posedge clk) disable iff (rst)
        !sat_flag && in_valid && operand == '0 |=> !sat_flag);     // R8

endmodule

// File: tb/sat_rnd_vshift_tb.sv
`timescale 1ns/1ps
module sat_rnd_vshift_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [63:0] operand, shamt;
    logic [1:0]  esize, mode;
    logic        round_en, sat_en, sat_clr;
    logic        out_valid;
    logic [63:0] result;
    logic        sat_flag;

    int n_run  = 0;
    int n_fail = 0;

    logic        exp_valid;
    logic [63:0] exp_res;
    logic        exp_flag;

    always #2.5 clk = ~clk;

    sat_rnd_vshift u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .operand(operand), .shamt(shamt),
        .esize(esize), .mode(mode), .round_en(round_en), .sat_en(sat_en),
        .sat_clr(sat_clr), .out_valid(out_valid), .result(result), .sat_flag(sat_flag)
    );

    function automatic longint unsigned lane_ref(input longint unsigned bits, input int w,
                                                 input int amt, input int md, input bit rnd,
                                                 input bit sten, output bit ev);
        longint unsigned mask, uv, satv;
        longint sv;
        bit sgn, neg, ok;
        mask = (w == 64) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << w) - 64'd1);
        uv   = bits & mask;
        neg  = ((uv >> (w - 1)) & 64'd1) != 0;
        sv   = neg ? longint'(uv | ~mask) : longint'(uv);
        sgn  = (md == 0);
        satv = sgn ? (neg ? (64'd1 << (w - 1)) : (mask >> 1)) : mask;
        ev   = 1'b0;
        if (md == 2 && sten && neg) begin
            ev = 1'b1;
            return 0;
        end
        if (amt < 0) begin
            int n = -amt;
            if (sgn) begin
                if (n >= w) return rnd ? 0 : (neg ? mask : 0);
                if (rnd) begin
                    longint t = sv >>> (n - 1);
                    return longint'((t >>> 1) + (t & 1)) & mask;
                end
                return longint'(sv >>> n) & mask;
            end else begin
                if (n >= w + int'(rnd)) return 0;
                if (rnd) begin
                    longint unsigned t = uv >> (n - 1);
                    return ((t >> 1) + (t & 1)) & mask;
                end
                return (uv >> n) & mask;
            end
        end
        if (amt >= w) begin
            if (sten && uv != 0) begin
                ev = 1'b1;
                return satv;
            end
            return 0;
        end
        if (sgn) begin
            longint v = sv <<< amt;
            if (w == 64) ok = ((v >>> amt) == sv);
            else ok = (v >= -(longint'(1) << (w - 1))) && (v < (longint'(1) << (w - 1)));
            if (!ok && sten) begin
                ev = 1'b1;
                return satv;
            end
            return longint'(v) & mask;
        end else begin
            longint unsigned v = uv << amt;
            if (w == 64) ok = ((v >> amt) == uv);
            else ok = ((v & ~mask) == 0);
            if (!ok && sten) begin
                ev = 1'b1;
                return satv;
            end
            return v & mask;
        end
    endfunction

    function automatic logic [63:0] word_ref(input logic [63:0] op, input logic [63:0] sh,
                                             input int es, input int md, input bit r,
                                             input bit s, output bit ev);
        int w = 8 << es;
        logic [63:0] acc = '0;
        ev = 1'b0;
        for (int i = 0; i < 64 / w; i++) begin
            bit e;
            longint unsigned lv;
            lv  = lane_ref(op >> (i * w), w, int'($signed(sh[i*w +: 8])), md, r, s, e);
            acc = acc | (lv << (i * w));
            ev  = ev | e;
        end
        return acc;
    endfunction

    // every lane's low byte = a, higher amount bits filled with noise (R1)
    function automatic logic [63:0] rep(input int w, input int a);
        logic [63:0] x = {$urandom, $urandom};
        for (int i = 0; i < 64 / w; i++) x[i*w +: 8] = 8'(a);
        return x;
    endfunction

    task automatic check(input string tag);
        n_run++;
        if (out_valid !== exp_valid || result !== exp_res || sat_flag !== exp_flag) begin
            n_fail++;
            $display("FAIL %s: valid=%b result=%h flag=%b expected valid=%b result=%h flag=%b",
                     tag, out_valid, result, sat_flag, exp_valid, exp_res, exp_flag);
        end
    endtask

    task automatic step(input logic v, input logic [63:0] op, input logic [63:0] sh,
                        input int es, input int md, input logic r, input logic s,
                        input logic c, input string tag);
        bit ev;
        logic [63:0] nr;
        in_valid = v; operand = op; shamt = sh; esize = 2'(es); mode = 2'(md);
        round_en = r; sat_en = s; sat_clr = c;
        nr = word_ref(op, sh, es, md, r, s, ev);
        @(posedge clk);
        exp_valid = v;
        if (v) exp_res = nr;
        exp_flag = (exp_flag & ~c) | (v & ev);
        @(negedge clk);
        check(tag);
    endtask

    initial begin
        #(200000 * 5);
        n_fail++;
        $display("FAIL watchdog: run did not complete");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1; in_valid = 0; operand = '0; shamt = '0; esize = 0; mode = 0;
        round_en = 0; sat_en = 0; sat_clr = 0;
        exp_valid = 0; exp_res = '0; exp_flag = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R12");
        step(0, 64'hDEAD, 64'h1, 0, 0, 0, 0, 0, "R12");

        // R1: each width, distinct per-lane amounts, noisy upper amount bits
        step(1, 64'h8123_4567_89AB_CDEF, 64'h80FF_01F8_0002_03FD, 0, 0, 0, 0, 0, "R1");
        for (int es = 0; es < 4; es++)
            step(1, {$urandom, $urandom}, rep(8 << es, -3), es, 1, 0, 0, 0, "R1");
        step(1, 64'h8000_0001_0000_7F00, 64'hFFFF_FF01_1234_5604, 2, 0, 0, 0, 0, "R1");

        // R2: truncating right shifts
        step(1, 64'h8001_7FFF_F00F_0FF0, rep(16, -4), 1, 0, 0, 0, 0, "R2");
        step(1, 64'h8001_7FFF_F00F_0FF0, rep(16, -4), 1, 1, 0, 0, 0, "R2");
        step(1, 64'hF000_0000_0000_0001, rep(64, -63), 3, 0, 0, 0, 0, "R2");

        // R3: rounded right shifts
        step(1, 64'h0506_FBFA_8180_7F7E, rep(8, -1), 0, 0, 1, 0, 0, "R3");
        step(1, 64'h0506_FBFA_8180_7F7E, rep(8, -1), 0, 1, 1, 0, 0, "R3");
        step(1, 64'h0000_0018_FFFF_FFE8, rep(32, -4), 2, 0, 1, 0, 0, "R3");
        step(1, 64'hC000_0000_0000_0000, rep(64, -63), 3, 0, 1, 0, 0, "R3");

        // R4: signed at or beyond the width
        step(1, 64'h8000_0001_7FFF_FFFF, rep(32, -32), 2, 0, 0, 0, 0, "R4");
        step(1, 64'h8000_0001_7FFF_FFFF, rep(32, -32), 2, 0, 1, 0, 0, "R4");
        step(1, 64'h80FF_7F01_8000_0001, rep(8, -100), 0, 0, 0, 0, 0, "R4");

        // R5: unsigned at or beyond the width
        step(1, 64'h8000_FFFF_7FFF_0001, rep(16, -16), 1, 1, 1, 0, 0, "R5");
        step(1, 64'h8000_FFFF_7FFF_0001, rep(16, -17), 1, 1, 1, 0, 0, "R5");
        step(1, 64'h8000_FFFF_7FFF_0001, rep(16, -16), 1, 1, 0, 0, 0, "R5");
        step(1, 64'h8000_0000_0000_0000, rep(64, -64), 3, 2, 1, 0, 0, "R5");

        // R6: left shifts without clamping
        step(1, 64'h4041_C0C1_0180_7F01, rep(8, 3), 0, 0, 0, 0, 0, "R6");
        step(1, 64'h4041_C0C1_0180_7F01, rep(8, 7), 0, 1, 0, 0, 0, "R6");
        step(1, 64'h0000_0001_FFFF_FFFF, rep(64, 63), 3, 0, 0, 0, 0, "R6");

        // R7: clamping left shifts
        step(1, 64'h4041_C0C1_0180_7F01, rep(8, 1), 0, 0, 0, 1, 0, "R7");
        step(1, 64'h0, 64'h0, 0, 0, 0, 0, 1, "R7");
        step(1, 64'h4000_0000_BFFF_FFFF, rep(32, 1), 2, 0, 0, 1, 0, "R7");
        step(1, 64'h0, 64'h0, 0, 0, 0, 0, 1, "R7");
        step(1, 64'h0001_8000_0000_7FFF, rep(16, 15), 1, 1, 0, 1, 0, "R7");
        step(1, 64'h0, 64'h0, 0, 0, 0, 0, 1, "R7");
        step(1, 64'hC000_0000_0000_0000, rep(64, 1), 3, 0, 0, 1, 0, "R7");

        // R8: amount at or past the width
        step(1, 64'h0, 64'h0, 0, 0, 0, 0, 1, "R8");
        step(1, 64'h0000_FF00_0100_8000, rep(16, 16), 1, 0, 0, 0, 0, "R8");
        step(1, 64'h0, rep(8, 8), 0, 0, 0, 1, 0, "R8");
        step(1, 64'h0, rep(64, 127), 3, 1, 0, 1, 0, "R8");
        step(1, 64'h0000_FF00_0100_8000, rep(16, 16), 1, 0, 0, 1, 0, "R8");

        // R9: signed-to-unsigned mode
        step(1, 64'h0, 64'h0, 0, 0, 0, 0, 1, "R9");
        step(1, 64'h0000_0080_0000_0000, rep(8, -1), 0, 2, 0, 1, 0, "R9");
        step(1, 64'h0, 64'h0, 0, 0, 0, 0, 1, "R9");
        step(1, 64'h7F01_0000_0000_0000, rep(8, 1), 0, 2, 0, 1, 0, "R9");
        step(1, 64'h80FF_F001_8000_0001, rep(16, -4), 1, 2, 1, 0, 0, "R9");
        step(1, 64'h80FF_F001_8000_0001, rep(16, -4), 1, 3, 1, 0, 0, "R9");

        // R10: hold while idle
        step(0, 64'h1234, rep(8, 1), 0, 0, 0, 0, 0, "R10");
        step(0, 64'hFFFF, rep(8, 2), 0, 1, 0, 1, 0, "R10");

        // R11: sticky, clear, and clear colliding with an event
        step(0, 64'h0, 64'h0, 0, 0, 0, 0, 1, "R11");
        step(1, 64'h7F00_0000_0000_0000, rep(8, 4), 0, 0, 0, 1, 0, "R11");
        step(1, 64'h01, rep(8, 1), 0, 0, 0, 0, 0, "R11");
        step(0, 64'h0, 64'h0, 0, 0, 0, 0, 0, "R11");
        step(1, 64'h7F00_0000_0000_0000, rep(8, 4), 0, 0, 0, 1, 1, "R11");
        step(0, 64'h0, 64'h0, 0, 0, 0, 0, 1, "R11");
        step(1, 64'h7F00_0000_0000_0000, rep(8, 4), 0, 0, 0, 0, 0, "R11");

        // random stimulus biased toward width-relative boundary amounts
        for (int k = 0; k < 1500; k++) begin
            int es = $urandom_range(3);
            int w = 8 << es;
            int bnd[10];
            logic [63:0] op, sh;
            bnd = '{w, w - 1, -w, -w - 1, -(w - 1), 0, 1, -1, 127, -128};
            sh = {$urandom, $urandom};
            for (int i = 0; i < 64 / w; i++)
                if ($urandom_range(1) == 1) sh[i*w +: 8] = 8'(bnd[$urandom_range(9)]);
            case ($urandom_range(4))
                0: op = '0;
                1: op = '1;
                2: op = {8{8'h80}};
                default: op = {$urandom, $urandom};
            endcase
            step(($urandom_range(3) != 0), op, sh, es, $urandom_range(3),
                 1'($urandom_range(1)), 1'($urandom_range(1)),
                 ($urandom_range(15) == 0), "RND");
        end

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule